// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block keeps the load-exclusive / store-exclusive reservations of several processors that share one memory. Every processor owns a request port that carries one of three operations: reserve a granule, attempt an exclusive store, or drop its own exclusive intent. The monitor holds one reservation entry and one local exclusive flag per processor. A single arbiter serialises all requests, so each check-and-invalidate step is atomic against reservations from other ports.

Addresses are compared at 16-byte granule resolution. A winning store-exclusive gets a one-cycle write enable toward memory. It also cancels the reservation of every processor that holds the same granule, so at most one competing store on a granule can win. A global clear pin empties the whole table.

Request ports use valid/ready. A port raises `req_valid` with its operation, address and size, and must hold them unchanged until it sees `req_ready` high at a rising edge. `req_ready` depends on `req_valid` of the same cycle and is high on at most one port. The result returns on `rsp_valid` exactly one cycle after the handshake and cannot be stalled.

Top module: `excl_mon`

## Requirements
- R1: Address bits [3:0] are ignored. Two addresses that differ only there refer to the same reservation granule.
- R2: `req_size` is the base-2 log of the access bytes, and codes 0 to 4 (1 to 16 bytes) are legal. A request with a size code of 5 to 7, or with op code 2'b11, returns fail (`rsp_fail`=1) and changes no entry and no flag.
- R3: A reserve (op 2'b00) writes the requester's entry with its granule, marks it valid and sets the requester's local flag. It returns `rsp_fail`=0 and leaves every other processor's entry unchanged.
- R4: A store-exclusive (op 2'b01) whose requester has a clear local flag fails and leaves the table untouched.
- R5: A store-exclusive with the local flag set fails when the requester's entry is invalid or holds a different granule, and it changes no entry.
- R6: A store-exclusive with the flag set whose own entry matches the granule succeeds (`rsp_fail`=0). It invalidates every entry, its own included, that holds the same granule.
- R7: `mem_we` is high only together with `rsp_valid` on the same port and only for a successful store. A failed store never raises it.
- R8: `glb_clear` invalidates all entries at the next edge. It takes effect after a request granted in the same cycle, so a reserve in that cycle is lost, while a store in that cycle is judged on the table as it stood before the clear.
- R9: A local drop (op 2'b10) clears only the requester's local flag and returns `rsp_fail`=0.
- R10: Every legal store-exclusive, whether it passes or fails, clears the requester's local flag.
- R11: At most one port is granted per cycle, and `req_ready` is high only on a requesting port. The grant rotates round-robin, starting after the last granted port. After reset, port 0 has the highest priority.
- R12: `rsp_valid` is high for exactly one cycle on the granted port, in the cycle after the handshake, and is low on every other port.
- R13: After reset all entries are invalid, all local flags are clear, and no response or write enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request present, one bit per port |
| req_ready | output | NPROC | Request accepted this cycle (grant) |
| req_op | input | 2*NPROC | Operation per port: 00 reserve, 01 store-exclusive, 10 local drop, 11 reserved |
| req_addr | input | AW*NPROC | Byte address per port |
| req_size | input | 3*NPROC | Log2 of access size in bytes per port |
| glb_clear | input | 1 | Invalidate all reservation entries |
| rsp_valid | output | NPROC | Response strobe, one cycle after the handshake |
| rsp_fail | output | NPROC | Status: 0 success, 1 failure |
| mem_we | output | NPROC | Write enable toward memory for a successful store |

## Verification
A granted request and `glb_clear` can fall in the same cycle, and so can several requests competing for one grant. The bench raises `glb_clear` together with a reserve, and then together with a store on a granule that is already reserved. The reserve must be lost and the store must still win. Random traffic from all ports on a few shared granules, with occasional clears, keeps several ports contending each cycle. Every grant, status and write enable is compared against a reference model of the table and the rotating arbiter.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_MARK  = 2'b00,
    OP_STORE = 2'b01,
    OP_LCLR  = 2'b10,
    OP_RSVD  = 2'b11
  } excl_op_e;

  localparam int GRAN_BITS     = 4;
  localparam int MAX_SIZE_CODE = 4;
  localparam int SIZE_W        = 3;
endpackage

// File: rtl/excl_rr_arb.sv
module excl_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(c);
        gnt[c]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

  a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r11_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r11_any_req_served: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> gnt_any);
endmodule

// File: rtl/excl_table.sv
module excl_table
  import excl_mon_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = AW - GRAN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [IW-1:0] op_idx,
  input  excl_op_e      op,
  input  logic [GW-1:0] op_gran,
  input  logic          op_legal,
  input  logic          glb_clear,
  output logic          res_fail,
  output logic          res_we
);
  logic [N-1:0]  ent_v;
  logic [N-1:0]  lflag;
  logic [GW-1:0] ent_a [N];
  logic [N-1:0]  match;
  logic          own_hit, store_ok, is_store;

  for (genvar i = 0; i < N; i++) begin : g_match
    assign match[i] = ent_v[i] && (ent_a[i] == op_gran);
  end

  always_comb begin
    is_store = op_valid && op_legal && (op == OP_STORE);
    own_hit  = match[op_idx];
    store_ok = is_store && lflag[op_idx] && own_hit;
    res_we   = store_ok;
    res_fail = !op_legal || ((op == OP_STORE) && !store_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      lflag <= '0;
      for (int i = 0; i < N; i++) ent_a[i] <= '0;
    end else begin
      if (op_valid && op_legal) begin
        unique case (op)
          OP_MARK: begin
            ent_v[op_idx] <= 1'b1;
            ent_a[op_idx] <= op_gran;
            lflag[op_idx] <= 1'b1;
          end
          OP_STORE: begin
            lflag[op_idx] <= 1'b0;
            if (store_ok) ent_v <= ent_v & ~match;
          end
          OP_LCLR: lflag[op_idx] <= 1'b0;
          default: ;
        endcase
      end
      if (glb_clear) ent_v <= '0;
    end
  end

  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    glb_clear |=> (ent_v == '0));
  a_r3_mark_written: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_legal && op == OP_MARK && !glb_clear)
      |=> (ent_v[$past(op_idx)] && lflag[$past(op_idx)]
           && ent_a[$past(op_idx)] == $past(op_gran)));
  a_r10_store_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> !lflag[$past(op_idx)]);
  a_r4_no_flag_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store && !lflag[op_idx]) |-> (res_fail && !res_we));
  a_r6_granule_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |=> ((ent_v & $past(match)) == '0));
  a_r2_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_legal && !glb_clear) |=> ($stable(ent_v) && $stable(lflag)));
endmodule

// File: rtl/excl_mon.sv
module excl_mon
  import excl_mon_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int AW    = 32,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int GW = AW - GRAN_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPROC-1:0]        req_valid,
  output logic [NPROC-1:0]        req_ready,
  input  logic [2*NPROC-1:0]      req_op,
  input  logic [AW*NPROC-1:0]     req_addr,
  input  logic [SIZE_W*NPROC-1:0] req_size,
  input  logic                    glb_clear,
  output logic [NPROC-1:0]        rsp_valid,
  output logic [NPROC-1:0]        rsp_fail,
  output logic [NPROC-1:0]        mem_we
);
  logic [NPROC-1:0] gnt;
  logic [IW-1:0]    gnt_idx;
  logic             gnt_any;
  excl_op_e         sel_op;
  logic [AW-1:0]    sel_addr;
  logic [SIZE_W-1:0] sel_size;
  logic             sel_legal, t_fail, t_we;

  excl_rr_arb #(.N(NPROC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  always_comb begin
    sel_op    = excl_op_e'(req_op[2*gnt_idx +: 2]);
    sel_addr  = req_addr[AW*gnt_idx +: AW];
    sel_size  = req_size[SIZE_W*gnt_idx +: SIZE_W];
    sel_legal = (int'(sel_size) <= MAX_SIZE_CODE) && (sel_op != OP_RSVD);
  end

  excl_table #(.N(NPROC), .AW(AW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .op_valid(gnt_any), .op_idx(gnt_idx), .op(sel_op),
    .op_gran(sel_addr[AW-1:GRAN_BITS]), .op_legal(sel_legal),
    .glb_clear(glb_clear),
    .res_fail(t_fail), .res_we(t_we)
  );

  assign req_ready = gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_fail  <= '0;
      mem_we    <= '0;
    end else begin
      rsp_valid <= gnt;
      rsp_fail  <= gnt & {NPROC{t_fail}};
      mem_we    <= gnt & {NPROC{t_we}};
    end
  end

  a_r7_we_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we & rsp_fail) == '0) && ((mem_we & ~rsp_valid) == '0));
  a_r12_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |-> ($past(req_valid) & rsp_valid) == rsp_valid);
endmodule

// File: tb/excl_mon_tb.sv
module excl_mon_tb;
  localparam int N  = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]     req_valid, req_ready, rsp_valid, rsp_fail, mem_we;
  logic [2*N-1:0]   req_op;
  logic [AW*N-1:0]  req_addr;
  logic [3*N-1:0]   req_size;
  logic             glb_clear = 1'b0;

  bit       pv [N];
  bit [1:0] pop [N];
  bit [31:0] paddr [N];
  bit [2:0] psz [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = pv[i];
      req_op[2*i +: 2]      = pop[i];
      req_addr[AW*i +: AW]  = paddr[i];
      req_size[3*i +: 3]    = psz[i];
    end
  end

  excl_mon #(.NPROC(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .glb_clear(glb_clear), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail),
    .mem_we(mem_we)
  );

  // reference model
  bit        m_v [N];
  bit        m_f [N];
  bit [27:0] m_a [N];
  int        m_last;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int model_grant();
    for (int k = 1; k <= N; k++) begin
      int c = (m_last + k) % N;
      if (pv[c]) return c;
    end
    return -1;
  endfunction

  // one clock cycle; entered and left at a falling edge
  task automatic cycle(string tag, bit clr);
    int g;
    bit efail, ewe;
    logic [N-1:0] exp_rdy;
    glb_clear = clr;
    #1;
    g = model_grant();
    exp_rdy = '0;
    efail = 0; ewe = 0;
    if (g >= 0) begin
      bit [27:0] gr = paddr[g][31:4];
      exp_rdy[g] = 1'b1;
      m_last = g;
      if (psz[g] > 3'd4 || pop[g] == 2'b11) efail = 1;
      else if (pop[g] == 2'b00) begin
        m_v[g] = 1; m_a[g] = gr; m_f[g] = 1;
      end else if (pop[g] == 2'b01) begin
        if (m_f[g] && m_v[g] && m_a[g] == gr) begin
          ewe = 1;
          for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == gr) m_v[i] = 0;
        end else efail = 1;
        m_f[g] = 0;
      end else m_f[g] = 0;
    end
    if (clr) for (int i = 0; i < N; i++) m_v[i] = 0;
    chk("R11 ready", {28'd0, req_ready}, {28'd0, exp_rdy});
    @(posedge clk);
    #1;
    glb_clear = 1'b0;
    if (g >= 0) pv[g] = 0;
    @(negedge clk);
    chk(tag, {20'd0, rsp_valid, rsp_fail, mem_we},
        {20'd0, exp_rdy, (g >= 0 && efail) ? exp_rdy : 4'd0,
         (g >= 0 && ewe) ? exp_rdy : 4'd0});
  endtask

  task automatic one(int p, bit [1:0] op, bit [31:0] a, bit [2:0] sz,
                     bit clr, string tag);
    pv[p] = 1; pop[p] = op; paddr[p] = a; psz[p] = sz;
    cycle(tag, clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) begin
      pv[i] = 0; pop[i] = 0; paddr[i] = 0; psz[i] = 0;
      m_v[i] = 0; m_f[i] = 0; m_a[i] = 0;
    end
    m_last = N - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle outputs", {20'd0, rsp_valid, rsp_fail, mem_we}, 32'd0);
    one(0, 2'b01, 32'h1000, 3'd2, 0, "R13 store after reset fails");

    // R1 / R6: granule match and invalidation of all holders
    one(0, 2'b00, 32'h2003, 3'd1, 0, "R3 mark p0");
    one(1, 2'b00, 32'h2008, 3'd3, 0, "R3 mark p1");
    one(0, 2'b01, 32'h200F, 3'd0, 0, "R1 R6 store in same granule");
    one(1, 2'b01, 32'h2000, 3'd2, 0, "R6 other holder lost reservation");

    // R5 / R10
    one(2, 2'b00, 32'h3000, 3'd4, 0, "R3 mark p2");
    one(2, 2'b01, 32'h3010, 3'd2, 0, "R5 mismatched granule fails");
    one(2, 2'b01, 32'h3000, 3'd2, 0, "R10 flag dropped by failed store");
    one(2, 2'b00, 32'h3000, 3'd2, 0, "R3 remark p2");
    one(2, 2'b01, 32'h3004, 3'd2, 0, "R6 store after remark passes");

    // R4 / R9
    one(3, 2'b00, 32'h4000, 3'd2, 0, "R3 mark p3");
    one(3, 2'b10, 32'h4000, 3'd0, 0, "R9 local drop returns ok");
    one(3, 2'b01, 32'h4000, 3'd2, 0, "R4 store without flag fails");
    one(3, 2'b00, 32'h4000, 3'd2, 0, "R3 mark p3 again");
    one(3, 2'b01, 32'h4000, 3'd2, 0, "R4 entry kept after flagless fail");
    one(0, 2'b00, 32'h5000, 3'd2, 0, "R3 mark p0");
    one(1, 2'b10, 32'h5000, 3'd2, 0, "R9 drop on p1");
    one(0, 2'b01, 32'h5000, 3'd2, 0, "R9 p0 flag unaffected by p1 drop");

    // R2 illegal size / op
    one(0, 2'b00, 32'h6000, 3'd5, 0, "R2 oversize mark fails");
    one(0, 2'b01, 32'h6000, 3'd2, 0, "R2 oversize mark left no flag");
    one(1, 2'b00, 32'h6100, 3'd2, 0, "R3 mark p1");
    one(1, 2'b11, 32'h6100, 3'd2, 0, "R2 reserved op fails");
    one(1, 2'b01, 32'h6100, 3'd7, 0, "R2 oversize store fails");
    one(1, 2'b01, 32'h6100, 3'd2, 0, "R2 state kept after illegal requests");

    // R3 independence of entries
    one(0, 2'b00, 32'h7000, 3'd2, 0, "R3 mark p0");
    one(1, 2'b00, 32'h7100, 3'd2, 0, "R3 mark p1");
    one(0, 2'b01, 32'h7000, 3'd2, 0, "R3 p0 store passes");
    one(1, 2'b01, 32'h7100, 3'd2, 0, "R3 p1 entry untouched");

    // R8 clear in same cycle as mark / store
    one(0, 2'b00, 32'h8000, 3'd2, 1, "R8 mark with clear");
    one(0, 2'b01, 32'h8000, 3'd2, 0, "R8 mark lost to clear");
    one(1, 2'b00, 32'h8100, 3'd2, 0, "R3 mark p1");
    one(1, 2'b01, 32'h8100, 3'd2, 1, "R8 store judged before clear");
    one(2, 2'b00, 32'h8200, 3'd2, 0, "R3 mark p2");
    cycle("R8 clear alone", 1);
    one(2, 2'b01, 32'h8200, 3'd2, 0, "R8 entry gone after clear");

    // R11 contention, R7 R12 in every cycle
    for (int i = 0; i < N; i++) begin
      pv[i] = 1; pop[i] = 2'b00; paddr[i] = 32'h9000; psz[i] = 3'd2;
    end
    for (int k = 0; k < N; k++) cycle("R11 R12 contending marks", 0);
    for (int i = 0; i < N; i++) begin
      pv[i] = 1; pop[i] = 2'b01; paddr[i] = 32'h9000; psz[i] = 3'd2;
    end
    for (int k = 0; k < N; k++) cycle("R6 R7 one winner per granule", 0);

    // random phase
    for (int t = 0; t < 3000; t++) begin
      for (int i = 0; i < N; i++) begin
        if (!pv[i] && ($urandom % 2 == 0)) begin
          int r = $urandom % 20;
          pv[i] = 1;
          pop[i] = (r < 8) ? 2'b00 : (r < 17) ? 2'b01 : (r < 19) ? 2'b10 : 2'b11;
          paddr[i] = 32'h1000 + ($urandom % 48);
          psz[i] = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
        end
      end
      cycle("R7 R12 random traffic", ($urandom % 25) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule